// File: doc/BRIEF.md
# Two-Shot Ultrasonic Ranging Sequencer

This block runs the timing side of an ultrasonic speed meter. It fires a transmit burst and counts tick periods until the first rising edge comes back on the echo input. It then waits a fixed interval and fires a second, identical shot. When both flight times are in hand, it publishes them together with a one-cycle done strobe and starts the next pair by itself. The difference between the two counts gives the distance the target moved in the interval. The arithmetic is left to downstream logic.

All timing advances on a tick enable, so one system clock can serve any time base. A shot that sees no echo before its flight counter would wrap is a timeout. A timeout abandons the whole pair, raises a timeout strobe and restarts at the first shot. The published counts keep their previous values.

Top module: `sonic_pair_ranger`

## Requirements
- R1: During and right after reset: phase is 0 (first shot), tx_o is 1, both published counts are 0, and done_o and timeout_o are 0.
- R2: In each shot, tx_o starts high and inverts once every HALF_TICKS ticks, counted from the first tick of the shot. It makes exactly 2*BURST_CYCLES inversions and then stays high. tx_o is forced high whenever a shot ends.
- R3: echo_i passes through two synchroniser flops. A shot detects an echo in the cycle after the synchronised echo rises, which is three clock edges after echo_i is first sampled high. The latched flight count is the number of tick cycles within the shot before that detection cycle.
- R4: An echo in the first shot moves phase to 1 (interval) and holds tx_o high.
- R5: The interval lasts exactly PERIODS*PERIOD_TICKS ticks. After that, phase becomes 2 (second shot), with cleared counters. Phase never takes the value 3.
- R6: An echo in the second shot publishes the first-shot count on first_cnt_o and the second-shot count on second_cnt_o, both at once. In that same cycle done_o is high for one cycle and phase returns to 0.
- R7: If a shot reaches its 2^CNT_W-th tick with no echo detected, timeout_o pulses for one cycle and phase returns to 0. Any first-shot result is discarded and the published counts are unchanged.
- R8: Echo edges during the interval have no effect. An echo level that is already high when a shot starts is not counted; only a new rising edge counts.
- R9: The published counts change only in a cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base enable; one count per high cycle |
| echo_i | input | 1 | Asynchronous echo receiver output |
| tx_o | output | 1 | Transmit drive, idles high |
| first_cnt_o | output | CNT_W | Published flight count of the first shot |
| second_cnt_o | output | CNT_W | Published flight count of the second shot |
| done_o | output | 1 | One-cycle strobe when a new pair is published |
| timeout_o | output | 1 | One-cycle strobe when a shot gives up |
| phase_o | output | 2 | 0 first shot, 1 interval, 2 second shot |

## Verification
A wrong phase shows on phase_o in the cycle it happens. A burst counter that slips shows on tx_o at the next inversion. A flight counter that drifts stays hidden until done_o publishes the pair, so an error surfaces only at the end of a full two-shot sequence. An interval counter that is off by one shifts the start of the second shot, and that shows one tick late on phase_o. A lost timeout shows as a phase that stays at a shot value long after 2^CNT_W ticks.

// File: rtl/sonic_pkg.sv
package sonic_pkg;

    typedef enum logic [1:0] {
        PH_SHOT_A = 2'd0,
        PH_GAP    = 2'd1,
        PH_SHOT_B = 2'd2
    } phase_e;

    localparam int SYNC_DEPTH = 2;

    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sonic_burst.sv
module sonic_burst
    import sonic_pkg::*;
#(
    parameter int HALF_TICKS   = 12,
    parameter int BURST_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic tx
);
    localparam int EDGES = 2 * BURST_CYCLES;
    localparam int HW    = bits_for(HALF_TICKS);
    localparam int TW    = bits_for(EDGES + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_TICKS - 1);
    localparam logic [TW-1:0] EDGE_END  = TW'(EDGES);

    logic [HW-1:0] half_q;
    logic [TW-1:0] edges_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            half_q  <= '0;
            edges_q <= '0;
            tx      <= 1'b1;
        end else if (step && (edges_q != EDGE_END)) begin
            if (half_q == HALF_LAST) begin
                half_q  <= '0;
                tx      <= ~tx;
                edges_q <= edges_q + 1'b1;
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sonic_flight.sv
module sonic_flight #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             at_max
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    assign at_max = &count;
endmodule

// File: rtl/sonic_gap.sv
module sonic_gap
    import sonic_pkg::*;
#(
    parameter int PERIOD_TICKS = 50000,
    parameter int PERIODS      = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int PW = bits_for(PERIOD_TICKS);
    localparam int NW = bits_for(PERIODS);
    localparam logic [PW-1:0] PER_LAST = PW'(PERIOD_TICKS - 1);
    localparam logic [NW-1:0] NUM_LAST = NW'(PERIODS - 1);

    logic [PW-1:0] sub_q;
    logic [NW-1:0] num_q;
    logic          wrap;

    assign wrap = step && (sub_q == PER_LAST);
    assign last = wrap && (num_q == NUM_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sub_q <= '0;
            num_q <= '0;
        end else if (wrap) begin
            sub_q <= '0;
            num_q <= num_q + 1'b1;
        end else if (step) begin
            sub_q <= sub_q + 1'b1;
        end
    end
endmodule

// File: rtl/sonic_pair_ranger.sv
module sonic_pair_ranger
    import sonic_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int HALF_TICKS   = 12,
    parameter int BURST_CYCLES = 20,
    parameter int PERIOD_TICKS = 50000,
    parameter int PERIODS      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             echo_i,
    output logic             tx_o,
    output logic [CNT_W-1:0] first_cnt_o,
    output logic [CNT_W-1:0] second_cnt_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic [1:0]       phase_o
);
    phase_e                phase_q;
    logic [SYNC_DEPTH-1:0] sync_q;
    logic                  echo_prev_q;
    logic                  echo_rise;
    logic                  in_shot;
    logic                  hit;
    logic                  expire;
    logic                  gap_end;
    logic                  xfer;
    logic [CNT_W-1:0]      flight;
    logic                  flight_max;
    logic [CNT_W-1:0]      hold_q;

    // Echo synchroniser and rising-edge detector
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q      <= '0;
            echo_prev_q <= 1'b0;
        end else begin
            sync_q      <= {sync_q[SYNC_DEPTH-2:0], echo_i};
            echo_prev_q <= sync_q[SYNC_DEPTH-1];
        end
    end
    assign echo_rise = sync_q[SYNC_DEPTH-1] & ~echo_prev_q;

    assign in_shot = (phase_q != PH_GAP);
    assign hit     = in_shot && echo_rise;
    assign expire  = in_shot && tick_i && flight_max && !echo_rise;
    assign xfer    = hit || expire || gap_end;

    sonic_burst #(
        .HALF_TICKS  (HALF_TICKS),
        .BURST_CYCLES(BURST_CYCLES)
    ) u_burst (
        .clk (clk),
        .rst (rst),
        .clr (xfer),
        .step(in_shot && tick_i),
        .tx  (tx_o)
    );

    sonic_flight #(
        .CNT_W(CNT_W)
    ) u_flight (
        .clk   (clk),
        .rst   (rst),
        .clr   (xfer),
        .step  (in_shot && tick_i),
        .count (flight),
        .at_max(flight_max)
    );

    sonic_gap #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .PERIODS     (PERIODS)
    ) u_gap (
        .clk (clk),
        .rst (rst),
        .clr (xfer),
        .step((phase_q == PH_GAP) && tick_i),
        .last(gap_end)
    );

    // Shot sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_SHOT_A;
            hold_q       <= '0;
            first_cnt_o  <= '0;
            second_cnt_o <= '0;
            done_o       <= 1'b0;
            timeout_o    <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            if (hit) begin
                if (phase_q == PH_SHOT_A) begin
                    hold_q  <= flight;
                    phase_q <= PH_GAP;
                end else begin
                    first_cnt_o  <= hold_q;
                    second_cnt_o <= flight;
                    done_o       <= 1'b1;
                    phase_q      <= PH_SHOT_A;
                end
            end else if (expire) begin
                timeout_o <= 1'b1;
                phase_q   <= PH_SHOT_A;
            end else if (gap_end) begin
                phase_q <= PH_SHOT_B;
            end
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/sonic_pair_ranger_chk.sv
module sonic_pair_ranger_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_o,
    input logic [CNT_W-1:0] first_cnt_o,
    input logic [CNT_W-1:0] second_cnt_o,
    input logic             done_o,
    input logic             timeout_o,
    input logic [1:0]       phase_o
);
    p_phase_legal_r5: assert property (@(posedge clk) disable iff (rst)
        phase_o != 2'd3);

    p_tx_idle_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1) |-> tx_o);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_after_b_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (phase_o == 2'd0) && ($past(phase_o) == 2'd2));

    p_b_after_gap_r5: assert property (@(posedge clk) disable iff (rst)
        ((phase_o == 2'd2) && ($past(phase_o) != 2'd2)) |-> ($past(phase_o) == 2'd1));

    p_timeout_restart_r7: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (phase_o == 2'd0) && !done_o);

    p_counts_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(first_cnt_o) && $stable(second_cnt_o));
endmodule

bind sonic_pair_ranger sonic_pair_ranger_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_o        (tx_o),
    .first_cnt_o (first_cnt_o),
    .second_cnt_o(second_cnt_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .phase_o     (phase_o)
);

// File: tb/sim_sonic_pair_ranger.sv
module sim_sonic_pair_ranger;
    localparam int CNT_W  = 8;
    localparam int HALF   = 2;
    localparam int BURST  = 20;
    localparam int PTICKS = 5;
    localparam int NPER   = 10;
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_i = 1'b0;
    logic             echo_i = 1'b0;
    logic             tx_o;
    logic [CNT_W-1:0] first_cnt_o;
    logic [CNT_W-1:0] second_cnt_o;
    logic             done_o;
    logic             timeout_o;
    logic [1:0]       phase_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int tcnt   = 0;
    bit ended  = 0;

    // reference model state
    int m_phase = 0, m_flight = 0, m_half = 0, m_edges = 0, m_tx = 1;
    int m_gap = 0, m_hold = 0, m_a = 0, m_b = 0, m_done = 0, m_to = 0;
    int s1 = 0, s2 = 0, s3 = 0;

    always #5 clk = ~clk;

    sonic_pair_ranger #(
        .CNT_W(CNT_W), .HALF_TICKS(HALF), .BURST_CYCLES(BURST),
        .PERIOD_TICKS(PTICKS), .PERIODS(NPER)
    ) u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .echo_i(echo_i),
        .tx_o(tx_o), .first_cnt_o(first_cnt_o), .second_cnt_o(second_cnt_o),
        .done_o(done_o), .timeout_o(timeout_o), .phase_o(phase_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic model_clear();
        m_flight = 0; m_half = 0; m_edges = 0; m_tx = 1; m_gap = 0;
    endtask

    // tick pattern: high two cycles out of three
    always @(posedge clk) begin
        #1;
        tcnt++;
        tick_i = (tcnt % 3) != 0;
    end

    // compare, then advance the model with the inputs the next edge will see
    always @(negedge clk) begin
        int rise;
        cycles++;
        check("R2 tx", int'(tx_o), m_tx);
        check("R4/R5 phase", int'(phase_o), m_phase);
        check("R3/R6/R9 first count", int'(first_cnt_o), m_a);
        check("R3/R6/R9 second count", int'(second_cnt_o), m_b);
        check("R6 done", int'(done_o), m_done);
        check("R7 timeout", int'(timeout_o), m_to);
        if (rst) begin
            m_phase = 0; m_hold = 0; m_a = 0; m_b = 0; m_done = 0; m_to = 0;
            s1 = 0; s2 = 0; s3 = 0;
            model_clear();
        end else begin
            rise = s2 & ~s3;
            s3 = s2; s2 = s1; s1 = int'(echo_i);
            m_done = 0; m_to = 0;
            if (m_phase != 1) begin
                if (rise != 0) begin
                    if (m_phase == 0) begin
                        m_hold = m_flight; m_phase = 1;
                    end else begin
                        m_a = m_hold; m_b = m_flight; m_done = 1; m_phase = 0;
                    end
                    model_clear();
                end else if (tick_i) begin
                    if (m_flight == MAXC) begin
                        m_to = 1; m_phase = 0;
                        model_clear();
                    end else begin
                        m_flight++;
                        if (m_edges < 2 * BURST) begin
                            if (m_half == HALF - 1) begin
                                m_half = 0; m_tx = 1 - m_tx; m_edges++;
                            end else begin
                                m_half++;
                            end
                        end
                    end
                end
            end else if (tick_i) begin
                m_gap++;
                if (m_gap == PTICKS * NPER) begin
                    m_phase = 2;
                    model_clear();
                end
            end
        end
        if (cycles > 30000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 30000);
            finish_run();
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_phase(input int p);
        while (int'(phase_o) != p) cyc(1);
    endtask

    task automatic pulse_echo(input int len);
        echo_i = 1'b1; cyc(len); echo_i = 1'b0;
    endtask

    initial begin
        int saved_a;
        int saved_b;
        cyc(4);
        check("R1 phase in reset", int'(phase_o), 0);
        check("R1 tx in reset", int'(tx_o), 1);
        check("R1 counts in reset", int'(first_cnt_o) + int'(second_cnt_o), 0);
        rst = 1'b0;
        cyc(1);
        check("R1 done after reset", int'(done_o), 0);

        // pair 1: first echo during burst, second after burst
        cyc(40); pulse_echo(3);
        wait_phase(1);
        cyc(20); pulse_echo(2); cyc(4);
        check("R8 gap ignores echo", int'(phase_o), 1);
        wait_phase(2);
        cyc(150); pulse_echo(2);
        cyc(10);

        // pair 2: echo level held across the gap into the second shot
        cyc(10); echo_i = 1'b1;
        wait_phase(1); wait_phase(2);
        cyc(30);
        check("R8 held level not counted", int'(phase_o), 2);
        echo_i = 1'b0; cyc(5); pulse_echo(3);
        cyc(10);

        // timeout in the first shot
        saved_a = int'(first_cnt_o); saved_b = int'(second_cnt_o);
        cyc(450);
        check("R7 counts kept after timeout", int'(first_cnt_o), saved_a);

        // timeout in the second shot discards the first result
        cyc(20); pulse_echo(2);
        wait_phase(2);
        cyc(450);
        check("R7 phase after second-shot timeout", int'(phase_o), 0);
        check("R7 first count unchanged", int'(first_cnt_o), saved_a);
        check("R7 second count unchanged", int'(second_cnt_o), saved_b);

        // pair 3: very early echoes
        pulse_echo(2);
        wait_phase(2);
        pulse_echo(2);
        cyc(20);
        finish_run();
    end
endmodule